// File: doc/BRIEF.md
# Strobe-Delayed Register Access Decoder

This block sits between a simple register bus and a bank of storage registers that live elsewhere. The bus presents a read address and a write address on separate inputs, each accompanied by a one-cycle strobe. The block turns the write address into a set of per-word write-select lines. It turns the read address into a word of read data and an access-valid flag. The storage registers take their write data straight from the bus and load it when their select line is high together with the write strobe.

Completion is timed rather than handshaken. Each strobe is shifted every clock into a three-stage history. The tap chosen by a delay parameter (0 to 2) marks the cycle in which the access completes. In that cycle the block raises done if the address was valid, or error if it was not, so a write to a read-only or unmapped word is reported instead of being silently acknowledged. The bus holds its address stable until done or error appears.

The map has a control word, a 16-bit read-only status word, a write-only command word, and a 64-bit register that spans two words. It also has a coefficient word with two variants. A two-bit field inside the control register chooses which variant a read returns and which variant's select line a write drives. Field codes with no variant behind them make the access invalid.

Top module: `regdec_top`

## Requirements
- R1: The word index is address bits [4:2]; bits [1:0] do not affect decode. A write address raises exactly one write-select line and sets wr_ok_o to 1 when the word is mapped for writing. The bit positions are: bit 0 for control (word 0), bit 1 for command (word 3), bit 2 for the wide register low half (word 4), bit 3 for its high half (word 5), and bit 4+v for coefficient variant v (word 2).
- R2: A write address at the status word (word 1) or at an unmapped word (6 or 7) raises no write-select line and drives wr_ok_o to 0.
- R3: The variant field is ctrl_val_i[5:4]. Code 0 selects coefficient variant 0 (coef_vars_i[31:0]) and code 1 selects variant 1 (coef_vars_i[63:32]), for both read data and write-select. Codes 2 and 3 give read data 0 with rd_ok_o 0, and no write-select with wr_ok_o 0.
- R4: A read with rd_ok_o 1 returns the following data. Word 0 returns ctrl_val_i. Word 1 returns status_val_i zero-extended to 32 bits. Word 4 returns ts_val_i[31:0] and word 5 returns ts_val_i[63:32].
- R5: A read of the write-only command word (word 3) or of an unmapped word returns data 0 with rd_ok_o 0.
- R6: A read strobe sampled at a rising edge produces rd_done_o high for exactly one cycle. That cycle follows the RD_DLY-th later rising edge (the cycle after the sampling edge when RD_DLY is 0), and rd_done_o is high only if rd_ok_o is 1 then.
- R7: A write strobe produces wr_done_o with the same timing, using WR_DLY and wr_ok_o.
- R8: With ERR_EN set, a strobe whose access is invalid produces rd_err_o or wr_err_o in place of done, in the same cycle. Done and error are never high together.
- R9: While rst_ni is low the strobe history is cleared, and strobes seen during reset produce no done or error after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_addr_i | input | 5 | Read byte address |
| wr_addr_i | input | 5 | Write byte address |
| rd_stb_i | input | 1 | One-cycle read strobe |
| wr_stb_i | input | 1 | One-cycle write strobe |
| ctrl_val_i | input | 32 | Current control register contents, carrying the variant field |
| status_val_i | input | 16 | Read-only status value |
| coef_vars_i | input | 64 | Coefficient variants, variant v in bits [32v+31:32v] |
| ts_val_i | input | 64 | Wide register contents |
| wr_sel_o | output | 6 | Per-word write-select lines |
| rd_data_o | output | 32 | Read data for rd_addr_i |
| rd_ok_o | output | 1 | Read address is valid |
| wr_ok_o | output | 1 | Write address is valid |
| rd_done_o | output | 1 | Read completion pulse |
| rd_err_o | output | 1 | Read error pulse |
| wr_done_o | output | 1 | Write completion pulse |
| wr_err_o | output | 1 | Write error pulse |

## Verification
The bench sweeps every word index with non-zero byte offsets. A decoder that sliced the wrong address bits would then select the wrong line or show a byte-offset dependence. It steps the variant field through all four codes on both paths. A design that treated the unused codes as a variant would return stale coefficient data or raise a select line with the OK flag set. Pulses are sampled over four cycles after each strobe, so an off-by-one tap or a stretched pulse shows up as done or error in the wrong cycle. Writes to the read-only word and reads of the write-only word must give error and never done. Strobes held during reset must leave no trace after release.

// File: rtl/regdec_pkg.sv
package regdec_pkg;

    // word indices inside the register area
    localparam int W_CTRL  = 0;
    localparam int W_STAT  = 1;
    localparam int W_COEF  = 2;
    localparam int W_CMD   = 3;
    localparam int W_TS_LO = 4;
    localparam int W_TS_HI = 5;

    // positions of the write-select lines
    localparam int S_CTRL  = 0;
    localparam int S_CMD   = 1;
    localparam int S_TS_LO = 2;
    localparam int S_TS_HI = 3;
    localparam int S_VAR0  = 4;

    // fixed select lines before the variant lines
    localparam int N_FIXED_SEL = 4;

    // depth of each strobe history
    localparam int HIST_W = 3;

endpackage

// File: rtl/regdec_wr_decode.sv
module regdec_wr_decode
    import regdec_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int NVAR  = 2,
    parameter int SEL_W = 2,
    localparam int NSEL = N_FIXED_SEL + NVAR
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic [SEL_W-1:0] var_sel_i,
    output logic [NSEL-1:0]  wr_sel_o,
    output logic             wr_ok_o
);

    always_comb begin
        wr_sel_o = '0;
        wr_ok_o  = 1'b0;
        case (idx_i)
            IDX_W'(W_CTRL): begin
                wr_sel_o[S_CTRL] = 1'b1;
                wr_ok_o          = 1'b1;
            end
            IDX_W'(W_CMD): begin
                wr_sel_o[S_CMD] = 1'b1;
                wr_ok_o         = 1'b1;
            end
            IDX_W'(W_TS_LO): begin
                wr_sel_o[S_TS_LO] = 1'b1;
                wr_ok_o           = 1'b1;
            end
            IDX_W'(W_TS_HI): begin
                wr_sel_o[S_TS_HI] = 1'b1;
                wr_ok_o           = 1'b1;
            end
            IDX_W'(W_COEF): begin
                // forward the select of the variant the field names
                for (int v = 0; v < NVAR; v++) begin
                    if (var_sel_i == SEL_W'(v)) begin
                        wr_sel_o[S_VAR0 + v] = 1'b1;
                        wr_ok_o              = 1'b1;
                    end
                end
            end
            default: begin
                // status is read-only; other words are unmapped
            end
        endcase
    end

endmodule

// File: rtl/regdec_rd_mux.sv
module regdec_rd_mux
    import regdec_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int DATA_W = 32,
    parameter int STAT_W = 16,
    parameter int NVAR   = 2,
    parameter int SEL_W  = 2
) (
    input  logic [IDX_W-1:0]       idx_i,
    input  logic [SEL_W-1:0]       var_sel_i,
    input  logic [DATA_W-1:0]      ctrl_val_i,
    input  logic [STAT_W-1:0]      status_val_i,
    input  logic [NVAR*DATA_W-1:0] coef_vars_i,
    input  logic [2*DATA_W-1:0]    ts_val_i,
    output logic [DATA_W-1:0]      rd_data_o,
    output logic                   rd_ok_o
);

    always_comb begin
        rd_data_o = '0;
        rd_ok_o   = 1'b0;
        case (idx_i)
            IDX_W'(W_CTRL): begin
                rd_data_o = ctrl_val_i;
                rd_ok_o   = 1'b1;
            end
            IDX_W'(W_STAT): begin
                rd_data_o = DATA_W'(status_val_i);
                rd_ok_o   = 1'b1;
            end
            IDX_W'(W_COEF): begin
                for (int v = 0; v < NVAR; v++) begin
                    if (var_sel_i == SEL_W'(v)) begin
                        rd_data_o = coef_vars_i[v*DATA_W +: DATA_W];
                        rd_ok_o   = 1'b1;
                    end
                end
            end
            IDX_W'(W_TS_LO): begin
                rd_data_o = ts_val_i[0 +: DATA_W];
                rd_ok_o   = 1'b1;
            end
            IDX_W'(W_TS_HI): begin
                rd_data_o = ts_val_i[DATA_W +: DATA_W];
                rd_ok_o   = 1'b1;
            end
            default: begin
                // command word is write-only; the rest is unmapped
            end
        endcase
    end

endmodule

// File: rtl/regdec_strobe_line.sv
module regdec_strobe_line
    import regdec_pkg::*;
#(
    parameter int DLY    = 0,
    parameter bit ERR_EN = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic stb_i,
    input  logic ok_i,
    output logic done_o,
    output logic err_o
);

    typedef struct packed {
        logic [HIST_W-1:0] hist;
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        line_d      = line_q;
        line_d.hist = {line_q.hist[HIST_W-2:0], stb_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) line_q <= '0;
        else         line_q <= line_d;
    end

    logic tap;
    assign tap    = line_q.hist[DLY];
    assign done_o = tap & ok_i;

    generate
        if (ERR_EN) begin : g_err
            assign err_o = tap & ~ok_i;
        end else begin : g_no_err
            assign err_o = 1'b0;
        end
    endgenerate

    logic unused_msb;
    assign unused_msb = line_q.hist[HIST_W-1];

    // R6 on the read instance, R7 on the write instance
    assert_done_after_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> $past(stb_i, DLY + 1));

    assert_err_after_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> $past(stb_i, DLY + 1));

    assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !$past(stb_i, DLY + 2)) |=> !done_o || $past(stb_i, DLY + 1));

endmodule

// File: rtl/regdec_top.sv
module regdec_top
    import regdec_pkg::*;
#(
    parameter int AREA_BITS = 5,
    parameter int BYTE_BITS = 2,
    parameter int DATA_W    = 32,
    parameter int STAT_W    = 16,
    parameter int NVAR      = 2,
    parameter int SEL_W     = 2,
    parameter int SEL_LSB   = 4,
    parameter int RD_DLY    = 2,
    parameter int WR_DLY    = 1,
    parameter bit ERR_EN    = 1'b1,
    localparam int IDX_W    = AREA_BITS - BYTE_BITS,
    localparam int NSEL     = N_FIXED_SEL + NVAR
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [AREA_BITS-1:0]   rd_addr_i,
    input  logic [AREA_BITS-1:0]   wr_addr_i,
    input  logic                   rd_stb_i,
    input  logic                   wr_stb_i,
    input  logic [DATA_W-1:0]      ctrl_val_i,
    input  logic [STAT_W-1:0]      status_val_i,
    input  logic [NVAR*DATA_W-1:0] coef_vars_i,
    input  logic [2*DATA_W-1:0]    ts_val_i,
    output logic [NSEL-1:0]        wr_sel_o,
    output logic [DATA_W-1:0]      rd_data_o,
    output logic                   rd_ok_o,
    output logic                   wr_ok_o,
    output logic                   rd_done_o,
    output logic                   rd_err_o,
    output logic                   wr_done_o,
    output logic                   wr_err_o
);

    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic [SEL_W-1:0] var_sel;
    logic             unused_byte_bits;

    assign rd_idx  = rd_addr_i[AREA_BITS-1:BYTE_BITS];
    assign wr_idx  = wr_addr_i[AREA_BITS-1:BYTE_BITS];
    assign var_sel = ctrl_val_i[SEL_LSB +: SEL_W];
    assign unused_byte_bits = ^{rd_addr_i[BYTE_BITS-1:0], wr_addr_i[BYTE_BITS-1:0]};

    regdec_wr_decode #(
        .IDX_W (IDX_W),
        .NVAR  (NVAR),
        .SEL_W (SEL_W)
    ) u_wr_dec (
        .idx_i     (wr_idx),
        .var_sel_i (var_sel),
        .wr_sel_o  (wr_sel_o),
        .wr_ok_o   (wr_ok_o)
    );

    regdec_rd_mux #(
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W),
        .STAT_W (STAT_W),
        .NVAR   (NVAR),
        .SEL_W  (SEL_W)
    ) u_rd_mux (
        .idx_i        (rd_idx),
        .var_sel_i    (var_sel),
        .ctrl_val_i   (ctrl_val_i),
        .status_val_i (status_val_i),
        .coef_vars_i  (coef_vars_i),
        .ts_val_i     (ts_val_i),
        .rd_data_o    (rd_data_o),
        .rd_ok_o      (rd_ok_o)
    );

    regdec_strobe_line #(.DLY(RD_DLY), .ERR_EN(ERR_EN)) u_rd_line (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .stb_i  (rd_stb_i),
        .ok_i   (rd_ok_o),
        .done_o (rd_done_o),
        .err_o  (rd_err_o)
    );

    regdec_strobe_line #(.DLY(WR_DLY), .ERR_EN(ERR_EN)) u_wr_line (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .stb_i  (wr_stb_i),
        .ok_i   (wr_ok_o),
        .done_o (wr_done_o),
        .err_o  (wr_err_o)
    );

    assert_wrsel_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(wr_sel_o));

    assert_wrsel_implies_ok_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_sel_o != '0) |-> wr_ok_o);

    assert_bad_read_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_ok_o |-> (rd_data_o == '0));

    assert_bad_variant_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (var_sel >= SEL_W'(NVAR)) |-> (wr_sel_o[NSEL-1:S_VAR0] == '0));

endmodule

// File: tb/tb_regdec_top.sv
module tb_regdec_top;

    localparam int RD_DLY = 2;
    localparam int WR_DLY = 1;
    localparam int NSEL   = 6;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  rd_addr, wr_addr;
    logic        rd_stb, wr_stb;
    logic [31:0] ctrl_val;
    logic [15:0] status_val;
    logic [63:0] coef_vars;
    logic [63:0] ts_val;
    logic [NSEL-1:0] wr_sel;
    logic [31:0] rd_data;
    logic        rd_ok, wr_ok, rd_done, rd_err, wr_done, wr_err;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    regdec_top #(.RD_DLY(RD_DLY), .WR_DLY(WR_DLY)) dut (
        .clk_i(clk), .rst_ni(rst_n),
        .rd_addr_i(rd_addr), .wr_addr_i(wr_addr),
        .rd_stb_i(rd_stb), .wr_stb_i(wr_stb),
        .ctrl_val_i(ctrl_val), .status_val_i(status_val),
        .coef_vars_i(coef_vars), .ts_val_i(ts_val),
        .wr_sel_o(wr_sel), .rd_data_o(rd_data),
        .rd_ok_o(rd_ok), .wr_ok_o(wr_ok),
        .rd_done_o(rd_done), .rd_err_o(rd_err),
        .wr_done_o(wr_done), .wr_err_o(wr_err)
    );

    localparam logic [31:0] CTRL_BASE = 32'hA5A5_0F00;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [NSEL-1:0] exp_wsel(input int w, input int code);
        case (w)
            0: return 6'b000001;
            3: return 6'b000010;
            4: return 6'b000100;
            5: return 6'b001000;
            2: return (code < 2) ? 6'(1 << (4 + code)) : 6'b0;
            default: return 6'b0;
        endcase
    endfunction

    function automatic logic [32:0] exp_rd(input int w, input int code);
        case (w)
            0: return {1'b1, CTRL_BASE | 32'(code << 4)};
            1: return {1'b1, 16'h0000, status_val};
            2: return (code < 2) ? {1'b1, coef_vars[code*32 +: 32]} : 33'h0;
            4: return {1'b1, ts_val[31:0]};
            5: return {1'b1, ts_val[63:32]};
            default: return 33'h0;
        endcase
    endfunction

    task automatic set_code(input int code);
        ctrl_val = CTRL_BASE | 32'(code << 4);
    endtask

    task automatic t_reset;
        // R9: strobes held during reset leave nothing behind
        rst_n = 1'b0; rd_stb = 1'b1; wr_stb = 1'b1;
        rd_addr = 5'd0; wr_addr = 5'd0;
        repeat (4) @(negedge clk);
        chk("R9 done/err in reset", {60'b0, rd_done, rd_err, wr_done, wr_err}, 64'h0);
        rst_n = 1'b1; rd_stb = 1'b0; wr_stb = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk("R9 no pulse after release", {60'b0, rd_done, rd_err, wr_done, wr_err}, 64'h0);
            @(negedge clk);
        end
    endtask

    task automatic t_wr_decode;
        set_code(0);
        for (int w = 0; w < 8; w++) begin
            for (int off = 0; off < 4; off += 3) begin
                wr_addr = 5'((w << 2) | off);
                #1;
                if (w == 1 || w >= 6)
                    chk("R2 no select on ro/unmapped", {57'b0, wr_ok, wr_sel}, 64'h0);
                else
                    chk("R1 write select", {57'b0, wr_ok, wr_sel}, {57'b0, 1'b1, exp_wsel(w, 0)});
            end
        end
    endtask

    task automatic t_rd_map;
        set_code(1);
        for (int w = 0; w < 8; w++) begin
            rd_addr = 5'((w << 2) | 2);
            #1;
            if (w == 3 || w >= 6)
                chk("R5 read wo/unmapped", {31'b0, rd_ok, rd_data}, 64'h0);
            else
                chk("R4 read map", {31'b0, rd_ok, rd_data}, {31'b0, exp_rd(w, 1)});
        end
    endtask

    task automatic t_variants;
        rd_addr = 5'd8; wr_addr = 5'd9;
        for (int code = 0; code < 4; code++) begin
            set_code(code);
            #1;
            chk("R3 variant read", {31'b0, rd_ok, rd_data}, {31'b0, exp_rd(2, code)});
            chk("R3 variant write", {57'b0, wr_ok, wr_sel},
                {57'b0, (code < 2), exp_wsel(2, code)});
        end
        set_code(0);
    endtask

    task automatic rd_pulse(input int w, input bit good);
        @(negedge clk);
        rd_addr = 5'(w << 2); rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        for (int k = 0; k < 4; k++) begin
            if (good) begin
                chk("R6 rd_done timing", {63'b0, rd_done}, {63'b0, k == RD_DLY});
                chk("R8 no rd_err on good read", {63'b0, rd_err}, 64'h0);
            end else begin
                chk("R8 rd_err timing", {63'b0, rd_err}, {63'b0, k == RD_DLY});
                chk("R8 no rd_done on bad read", {63'b0, rd_done}, 64'h0);
            end
            @(negedge clk);
        end
    endtask

    task automatic wr_pulse(input int w, input bit good);
        @(negedge clk);
        wr_addr = 5'(w << 2); wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        for (int k = 0; k < 4; k++) begin
            if (good) begin
                chk("R7 wr_done timing", {63'b0, wr_done}, {63'b0, k == WR_DLY});
                chk("R8 no wr_err on good write", {63'b0, wr_err}, 64'h0);
            end else begin
                chk("R8 wr_err timing", {63'b0, wr_err}, {63'b0, k == WR_DLY});
                chk("R8 no wr_done on bad write", {63'b0, wr_done}, 64'h0);
            end
            @(negedge clk);
        end
    endtask

    task automatic t_timing;
        set_code(0);
        rd_pulse(0, 1'b1);
        rd_pulse(5, 1'b1);
        rd_pulse(3, 1'b0);
        rd_pulse(7, 1'b0);
        wr_pulse(4, 1'b1);
        wr_pulse(1, 1'b0);
        wr_pulse(6, 1'b0);
        set_code(3);
        rd_pulse(2, 1'b0);
        wr_pulse(2, 1'b0);
        set_code(1);
        wr_pulse(2, 1'b1);
    endtask

    initial begin
        status_val = 16'hBEEF;
        coef_vars  = {32'h3333_4444, 32'h1111_2222};
        ts_val     = 64'h0123_4567_89AB_CDEF;
        ctrl_val   = CTRL_BASE;
        t_reset();
        t_wr_decode();
        t_rd_map();
        t_variants();
        t_timing();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20000 * 5);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule